// File: doc/BRIEF.md
# Calculator Number Entry Register

This block turns decoded keypad events into the operand that a pocket calculator shows and hands to its arithmetic unit. Each event is a single-cycle strobe with a 4-bit key code. Digit keys build an eight-digit BCD value that enters from the right. Separate keys place a decimal point, flip the sign, wipe the number being typed, or reset everything. The current operand is driven in parallel as BCD digits, a sign bit, a point-present bit and a fraction-digit count, so a display driver and an arithmetic unit can both read it.

An arithmetic unit outside the block pulses `new_entry_i` after it has produced a result. The next digit or point key then starts a fresh number instead of extending the one on show. The same unit raises `err_set_i` on overflow or division by zero. The block then latches a sticky error together with its polarity. The polarity selects a 'C' symbol (positive) or an 'E' symbol (negative). In the error state the block ignores every key except clear-all.

Top module: `ne_entry_reg`

## Requirements
- R1: After a synchronous reset, the operand is zero and positive, with no point and a fraction count of 0, and the error flag is low.
- R2: A digit key (codes 0 to 9) shifts the held BCD digits one place toward the most significant end and puts the new digit in the least significant position, digit 0 being bits [3:0].
- R3: A digit key is ignored once eight significant digits are held.
- R4: A zero key pressed while the operand holds no significant digit and no point leaves the value at zero and does not count toward the eight-digit limit.
- R5: The first point key (code 10) sets `point_o` and counts an implied integer zero as one digit if none was typed. Each later accepted digit raises `frac_o` by one. Further point keys in the same entry change nothing.
- R6: The sign key (code 11) toggles `neg_o` at any time during entry and leaves digits, point and fraction count unchanged.
- R7: Clear-entry (code 12) returns the operand to positive zero with no point. It leaves the error flag untouched.
- R8: Clear-all (code 13) returns the block to its reset state, including leaving the error state, and takes priority over `err_set_i` in the same cycle.
- R9: `err_set_i` while no error is held sets `err_o` and copies `err_neg_i` to `err_e_o` (1 = 'E', 0 = 'C'). While `err_o` is high, all keys except clear-all, further `err_set_i` pulses and `new_entry_i` have no effect.
- R10: After `new_entry_i` is pulsed (or in the same cycle), the next digit or point key first replaces the operand with positive zero and then applies the key. A sign key in between acts on the displayed value and does not use up the pending fresh start.
- R11: Key codes 14 and 15 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| key_vld_i | input | 1 | One-cycle key event strobe |
| key_code_i | input | 4 | Key code: 0-9 digit, 10 point, 11 sign, 12 clear entry, 13 clear all |
| new_entry_i | input | 1 | Next digit or point starts a fresh operand |
| err_set_i | input | 1 | Raise the sticky error state |
| err_neg_i | input | 1 | Polarity of the error being raised (1 negative) |
| digits_o | output | 32 | Operand as eight BCD digits, digit 0 in bits [3:0] |
| neg_o | output | 1 | Operand sign, 1 = negative |
| point_o | output | 1 | A decimal point has been entered |
| frac_o | output | 3 | Number of digits to the right of the point |
| err_o | output | 1 | Sticky error state |
| err_e_o | output | 1 | Error symbol: 1 = 'E' (negative), 0 = 'C' |

## Verification
The bench targets the ninth-digit boundary from both sides. It uses an integer entry, and a fraction that starts with a bare point, where the implied zero must count. A wrong limit would either drop the eighth digit or shift the most significant one out. Leading zero keys are applied before a limit test, so a design that counts them would refuse valid digits. Repeated points, a sign flip during a fresh-start window, and every key fed into the error state catch three faults: a point position that moves, a sign key that clears the pending start, and an error that leaks digits or polarity changes.

// File: rtl/ne_pkg.sv
package ne_pkg;

  typedef enum logic [3:0] {
    K_POINT = 4'd10,
    K_SIGN  = 4'd11,
    K_CE    = 4'd12,
    K_CA    = 4'd13
  } ne_key_e;

  typedef struct packed {
    logic       dig;
    logic       pnt;
    logic       sgn;
    logic       ce;
    logic       ca;
    logic [3:0] val;
  } ne_cmd_t;

endpackage

// File: rtl/ne_key_decode.sv
module ne_key_decode
  import ne_pkg::*;
(
  input  logic       vld_i,
  input  logic [3:0] code_i,
  output ne_cmd_t    cmd_o
);

  always_comb begin
    cmd_o     = '0;
    cmd_o.val = code_i;
    if (vld_i) begin
      if (code_i <= 4'd9) cmd_o.dig = 1'b1;
      else begin
        case (code_i)
          K_POINT: cmd_o.pnt = 1'b1;
          K_SIGN:  cmd_o.sgn = 1'b1;
          K_CE:    cmd_o.ce  = 1'b1;
          K_CA:    cmd_o.ca  = 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ne_operand_next.sv
module ne_operand_next
  import ne_pkg::*;
#(
  parameter int NDIG = 8,
  parameter int DW   = 4,
  localparam int VW  = NDIG * DW,
  localparam int CW  = $clog2(NDIG + 1),
  localparam int PW  = $clog2(NDIG)
) (
  input  ne_cmd_t         cmd_i,
  input  logic            fresh_i,
  input  logic [VW-1:0]   digits_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic            pseen_i,
  input  logic [PW-1:0]   frac_i,
  input  logic            neg_i,
  output logic [VW-1:0]   digits_o,
  output logic [CW-1:0]   cnt_o,
  output logic            pseen_o,
  output logic [PW-1:0]   frac_o,
  output logic            neg_o,
  output logic            consume_o
);

  localparam logic [CW-1:0] CMAX = CW'(NDIG);

  logic          restart;
  logic [VW-1:0] b_digits;
  logic [CW-1:0] b_cnt;
  logic          b_pseen;
  logic [PW-1:0] b_frac;
  logic          b_neg;
  logic [VW-1:0] shifted;
  logic          accept;

  assign restart   = fresh_i & (cmd_i.dig | cmd_i.pnt);
  assign consume_o = cmd_i.dig | cmd_i.pnt | cmd_i.ce;

  assign b_digits = restart ? '0 : digits_i;
  assign b_cnt    = restart ? '0 : cnt_i;
  assign b_pseen  = restart ? 1'b0 : pseen_i;
  assign b_frac   = restart ? '0 : frac_i;
  assign b_neg    = restart ? 1'b0 : neg_i;

  for (genvar i = 0; i < NDIG; i++) begin : g_lane
    if (i == 0) begin : g_lsd
      assign shifted[DW-1:0] = cmd_i.val[DW-1:0];
    end else begin : g_up
      assign shifted[i*DW +: DW] = b_digits[(i-1)*DW +: DW];
    end
  end

  assign accept = (b_cnt < CMAX) &&
                  !((b_cnt == '0) && (cmd_i.val == 4'd0) && !b_pseen);

  always_comb begin
    digits_o = b_digits;
    cnt_o    = b_cnt;
    pseen_o  = b_pseen;
    frac_o   = b_frac;
    neg_o    = b_neg;
    if (cmd_i.ce) begin
      digits_o = '0;
      cnt_o    = '0;
      pseen_o  = 1'b0;
      frac_o   = '0;
      neg_o    = 1'b0;
    end else if (cmd_i.dig) begin
      if (accept) begin
        digits_o = shifted;
        cnt_o    = b_cnt + CW'(1);
        if (b_pseen) frac_o = b_frac + PW'(1);
      end
    end else if (cmd_i.pnt) begin
      if (!b_pseen) begin
        pseen_o = 1'b1;
        if (b_cnt == '0) cnt_o = CW'(1);
      end
    end else if (cmd_i.sgn) begin
      neg_o = ~b_neg;
    end
  end

endmodule

// File: rtl/ne_err_latch.sv
module ne_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic set_i,
  input  logic neg_i,
  output logic err_o,
  output logic neg_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      err_o <= 1'b0;
      neg_o <= 1'b0;
    end else if (set_i && !err_o) begin
      err_o <= 1'b1;
      neg_o <= neg_i;
    end
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_o && !clr_i) |=> (err_o && $stable(neg_o)));

endmodule

// File: rtl/ne_entry_reg.sv
module ne_entry_reg
  import ne_pkg::*;
#(
  parameter int NDIG = 8,
  parameter int DW   = 4,
  localparam int VW  = NDIG * DW,
  localparam int CW  = $clog2(NDIG + 1),
  localparam int PW  = $clog2(NDIG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_vld_i,
  input  logic [3:0]    key_code_i,
  input  logic          new_entry_i,
  input  logic          err_set_i,
  input  logic          err_neg_i,
  output logic [VW-1:0] digits_o,
  output logic          neg_o,
  output logic          point_o,
  output logic [PW-1:0] frac_o,
  output logic          err_o,
  output logic          err_e_o
);

  ne_cmd_t       cmd;
  logic          pend_q;
  logic          fresh;
  logic [CW-1:0] cnt_q;
  logic [VW-1:0] n_digits;
  logic [CW-1:0] n_cnt;
  logic          n_pseen;
  logic [PW-1:0] n_frac;
  logic          n_neg;
  logic          consume;

  assign fresh = pend_q | new_entry_i;

  ne_key_decode u_dec (
    .vld_i  (key_vld_i),
    .code_i (key_code_i),
    .cmd_o  (cmd)
  );

  ne_operand_next #(.NDIG(NDIG), .DW(DW)) u_next (
    .cmd_i     (cmd),
    .fresh_i   (fresh),
    .digits_i  (digits_o),
    .cnt_i     (cnt_q),
    .pseen_i   (point_o),
    .frac_i    (frac_o),
    .neg_i     (neg_o),
    .digits_o  (n_digits),
    .cnt_o     (n_cnt),
    .pseen_o   (n_pseen),
    .frac_o    (n_frac),
    .neg_o     (n_neg),
    .consume_o (consume)
  );

  ne_err_latch u_err (
    .clk   (clk),
    .rst   (rst),
    .clr_i (cmd.ca),
    .set_i (err_set_i),
    .neg_i (err_neg_i),
    .err_o (err_o),
    .neg_o (err_e_o)
  );

  always_ff @(posedge clk) begin
    if (rst || cmd.ca) begin
      digits_o <= '0;
      cnt_q    <= '0;
      point_o  <= 1'b0;
      frac_o   <= '0;
      neg_o    <= 1'b0;
      pend_q   <= 1'b0;
    end else if (!err_o) begin
      digits_o <= n_digits;
      cnt_q    <= n_cnt;
      point_o  <= n_pseen;
      frac_o   <= n_frac;
      neg_o    <= n_neg;
      pend_q   <= fresh & ~consume;
    end
  end

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
    (key_vld_i && key_code_i == 4'd13) |=>
      (digits_o == '0 && !neg_o && !point_o && frac_o == '0 && !err_o));

  assert_frozen_in_error_R9: assert property (@(posedge clk) disable iff (rst)
    (err_o && !(key_vld_i && key_code_i == 4'd13)) |=>
      ($stable(digits_o) && $stable(neg_o) && $stable(point_o) && $stable(frac_o)));

  assert_sign_keeps_digits_R6: assert property (@(posedge clk) disable iff (rst)
    (key_vld_i && key_code_i == 4'd11 && !err_o) |=>
      ($stable(digits_o) && $stable(point_o) && $stable(frac_o) && neg_o != $past(neg_o)));

  assert_second_point_R5: assert property (@(posedge clk) disable iff (rst)
    (key_vld_i && key_code_i == 4'd10 && point_o && !fresh && !err_o) |=>
      ($stable(digits_o) && $stable(frac_o) && point_o));

  assert_full_ignores_digit_R3: assert property (@(posedge clk) disable iff (rst)
    (key_vld_i && key_code_i <= 4'd9 && cnt_q == CW'(NDIG) && !fresh && !err_o) |=>
      $stable(digits_o));

  assert_unused_codes_R11: assert property (@(posedge clk) disable iff (rst)
    (key_vld_i && key_code_i >= 4'd14 && !new_entry_i && !err_set_i) |=>
      ($stable(digits_o) && $stable(neg_o) && $stable(point_o) && $stable(err_o)));

endmodule

// File: tb/ne_entry_reg_tb_top.sv
module ne_entry_reg_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_vld = 1'b0;
  logic [3:0]  key_code = 4'd0;
  logic        new_entry = 1'b0;
  logic        err_set = 1'b0;
  logic        err_neg = 1'b0;
  logic [31:0] digits;
  logic        neg, point, err, err_e;
  logic [2:0]  frac;

  always #10 clk = ~clk;

  ne_entry_reg dut_i (
    .clk(clk), .rst(rst), .key_vld_i(key_vld), .key_code_i(key_code),
    .new_entry_i(new_entry), .err_set_i(err_set), .err_neg_i(err_neg),
    .digits_o(digits), .neg_o(neg), .point_o(point), .frac_o(frac),
    .err_o(err), .err_e_o(err_e)
  );

  // behavioural reference model
  longint m_val;
  int     m_cnt, m_frac;
  bit     m_pt, m_neg, m_err, m_e, m_pend, m_live;
  int     vectors = 0, miscompares = 0, cycles = 0;
  string  cur_req = "R1";
  bit     done = 1'b0;

  task automatic m_zero();
    m_val = 0; m_cnt = 0; m_pt = 0; m_frac = 0; m_neg = 0;
  endtask

  always @(posedge clk) begin
    bit fresh;
    m_live = 1'b1;
    if (rst) begin
      m_zero(); m_err = 0; m_e = 0; m_pend = 0;
    end else if (key_vld && key_code == 4'd13) begin
      m_zero(); m_err = 0; m_e = 0; m_pend = 0;
    end else if (!m_err) begin
      fresh = m_pend || new_entry;
      m_pend = fresh;
      if (key_vld) begin
        if (key_code <= 9) begin
          if (fresh) m_zero();
          m_pend = 0;
          if (m_cnt < 8 && !(m_cnt == 0 && key_code == 0 && !m_pt)) begin
            m_val = m_val * 10 + key_code;
            m_cnt++;
            if (m_pt) m_frac++;
          end
        end else if (key_code == 10) begin
          if (fresh) m_zero();
          m_pend = 0;
          if (!m_pt) begin m_pt = 1; if (m_cnt == 0) m_cnt = 1; end
        end else if (key_code == 11) m_neg = !m_neg;
        else if (key_code == 12) begin m_zero(); m_pend = 0; end
      end
      if (err_set) begin m_err = 1; m_e = err_neg; end
    end
  end

  function automatic longint bcd2int(input logic [31:0] b);
    longint v = 0;
    for (int i = 7; i >= 0; i--) v = v * 10 + b[i*4 +: 4];
    return v;
  endfunction

  always @(negedge clk) begin
    if (m_live && !done) begin
      vectors++;
      if (bcd2int(digits) !== m_val || neg !== m_neg || point !== m_pt ||
          frac !== m_frac[2:0] || err !== m_err || err_e !== m_e) begin
        miscompares++;
        $display("FAIL %s: got val=%0d neg=%b pt=%b frac=%0d err=%b e=%b, expected val=%0d neg=%b pt=%b frac=%0d err=%b e=%b",
                 cur_req, bcd2int(digits), neg, point, frac, err, err_e,
                 m_val, m_neg, m_pt, m_frac, m_err, m_e);
      end
    end
  end

  task automatic key(input int c);
    @(negedge clk); key_vld = 1'b1; key_code = 4'(c);
    @(negedge clk); key_vld = 1'b0;
  endtask

  task automatic pulse_new();
    @(negedge clk); new_entry = 1'b1;
    @(negedge clk); new_entry = 1'b0;
  endtask

  task automatic raise_err(input bit n);
    @(negedge clk); err_set = 1'b1; err_neg = n;
    @(negedge clk); err_set = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles, expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R2 and R3: nine digits, the ninth dropped
    cur_req = "R2";
    for (int d = 1; d <= 8; d++) key(d);
    cur_req = "R3";
    key(9); key(0);
    cur_req = "R7";
    key(12);
    // R4: leading zeros then eight significant digits
    cur_req = "R4";
    key(0); key(0); key(0);
    for (int d = 9; d >= 2; d--) key(d);
    key(5);
    key(12);
    // R5: 1 . 2 . 3 -> 1.23
    cur_req = "R5";
    key(1); key(10); key(2); key(10); key(3);
    key(12);
    // bare point: implied zero counts, 7 fraction digits max
    key(10); key(0);
    for (int d = 1; d <= 7; d++) key(d);
    // R6: sign anywhere
    cur_req = "R6";
    key(11); key(11); key(11);
    key(12);
    key(2); key(11); key(3); key(10); key(4);
    // R10: fresh start after result, sign does not consume it
    cur_req = "R10";
    pulse_new();
    key(11); key(7); key(8);
    pulse_new(); key(10); key(5);
    @(negedge clk); new_entry = 1'b1; key_vld = 1'b1; key_code = 4'd6;
    @(negedge clk); new_entry = 1'b0; key_vld = 1'b0;
    // R11: unused codes
    cur_req = "R11";
    key(14); key(15);
    // R9: error sticky, negative symbol
    cur_req = "R9";
    raise_err(1'b1);
    key(3); key(10); key(11); key(12); pulse_new(); raise_err(1'b0); key(4);
    // R8: clear all leaves error, then positive error and same-cycle priority
    cur_req = "R8";
    key(13);
    key(4); key(2);
    cur_req = "R9";
    raise_err(1'b0);
    key(1);
    cur_req = "R8";
    @(negedge clk); key_vld = 1'b1; key_code = 4'd13; err_set = 1'b1; err_neg = 1'b1;
    @(negedge clk); key_vld = 1'b0; err_set = 1'b0;
    key(5); key(12);
    repeat (3) @(negedge clk);
    // R1: reset mid-entry returns to power-up state
    cur_req = "R1";
    key(8); raise_err(1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule